// File: doc/BRIEF.md
# Duplex-Channel Fault Isolation Sequencer

Two identical measurement channels run side by side, and each one produces a value for the same sample instant. This block compares the two values on every sample. If they differ by more than a programmable tolerance, it starts an ordered chain of diagnostic steps. Each step depends only on parts that an earlier step has already cleared. The steps run in this order:

1. The built-in self-test verdict of each channel.
2. The regularity of each channel's timestamp stream over a programmable number of intervals.
3. The channel's converter with a zero input, which exposes bits stuck at one.
4. The converter with a full-scale input, which exposes bits stuck at zero.

Both channels are diagnosed together. A separate timer checks the supply-in-range flags at a selectable period, and this check runs whether or not a diagnosis is in progress. A channel found faulty is blocked, and the block stays latched until an explicit clear. A 3-bit verdict code records the step that found the fault. When no step finds a fault, the verdict code says the mismatch lies outside the channel hardware. Data keeps flowing from the channel that is not blocked.

Top module: `dual_chan_isolator`

## Requirements
- R1: A sample with `smp_vld` high, neither channel blocked and |`val_a`−`val_b`| strictly greater than `mis_tol` starts a diagnosis (`busy` goes high). A difference equal to `mis_tol` does not start one.
- R2: The supply flags are sampled once every `sup_period`+1 cycles. A low flag blocks its channel and sets `verdict` to 1, whatever the sequencer is doing.
- R3: The first step reads `bist_ok_a`/`bist_ok_b`. A low flag blocks that channel with `verdict` 2, and the diagnosis ends.
- R4: The timing step takes `k_int`+1 `ts_vld` pulses, which give `k_int` intervals. An interval whose distance from `ts_period` exceeds `ts_tol` blocks its channel with `verdict` 3.
- R5: The zero step drives `cnv_mode`=01 and waits for `cnv_vld`. A code above `cnv_tol` blocks the channel with `verdict` 4.
- R6: The full-scale step drives `cnv_mode`=10. A code below 2^CW−1−`cnv_tol` blocks the channel with `verdict` 5.
- R7: When every step passes, `verdict` becomes 7 and no channel is blocked.
- R8: When both channels fail the same step, both are blocked and `dual_alarm` is raised.
- R9: Blocks, `verdict` and `dual_alarm` hold until `clr`, which zeroes them and aborts any diagnosis. No new diagnosis starts while any channel is blocked.
- R10: `data_out` is `val_b` when only channel A is blocked and `val_a` otherwise. `data_vld` follows `smp_vld` unless both channels are blocked.
- R11: After reset, the block outputs, `dual_alarm`, `busy` and `verdict` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clears blocks, verdict and alarm |
| smp_vld | input | 1 | Both channel values valid |
| val_a | input | W | Channel A value |
| val_b | input | W | Channel B value |
| mis_tol | input | W | Mismatch tolerance |
| sup_ok_a | input | 1 | Channel A supply in range |
| sup_ok_b | input | 1 | Channel B supply in range |
| sup_period | input | 16 | Supply check interval minus one |
| bist_ok_a | input | 1 | Channel A self-test pass |
| bist_ok_b | input | 1 | Channel B self-test pass |
| ts_vld | input | 1 | Timestamps valid |
| ts_a | input | TW | Channel A timestamp |
| ts_b | input | TW | Channel B timestamp |
| ts_period | input | TW | Nominal sample period |
| ts_tol | input | TW | Period tolerance |
| k_int | input | 4 | Intervals to examine (at least 1) |
| cnv_vld | input | 1 | Converter test codes valid |
| cnv_a | input | CW | Channel A converter code |
| cnv_b | input | CW | Channel B converter code |
| cnv_tol | input | CW | Converter code tolerance |
| cnv_mode | output | 2 | Test input request: 01 zero, 10 full scale |
| busy | output | 1 | Diagnosis in progress |
| block_a | output | 1 | Channel A blocked |
| block_b | output | 1 | Channel B blocked |
| dual_alarm | output | 1 | Both channels failed one step |
| verdict | output | 3 | Failing step code |
| data_out | output | W | Value from healthy channel |
| data_vld | output | 1 | data_out valid |

## Verification
If the step register is corrupted, the wrong `cnv_mode` request or a wrong `verdict` code appears at the ports. This shows within one cycle of the pulse that should have advanced or ended the step. A bad interval counter or timestamp latch changes the verdict after the `k_int`-th interval, and it can also leave `busy` high with no verdict. A latch that fails to hold shows as `data_out` switching to the wrong channel, or as a fresh diagnosis starting on the next mismatched sample.

// File: rtl/dual_chan_isolator.sv
module dual_chan_isolator #(
  parameter int W  = 16,
  parameter int TW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_vld,
  input  logic [W-1:0]  val_a,
  input  logic [W-1:0]  val_b,
  input  logic [W-1:0]  mis_tol,
  input  logic          sup_ok_a,
  input  logic          sup_ok_b,
  input  logic [15:0]   sup_period,
  input  logic          bist_ok_a,
  input  logic          bist_ok_b,
  input  logic          ts_vld,
  input  logic [TW-1:0] ts_a,
  input  logic [TW-1:0] ts_b,
  input  logic [TW-1:0] ts_period,
  input  logic [TW-1:0] ts_tol,
  input  logic [3:0]    k_int,
  input  logic          cnv_vld,
  input  logic [CW-1:0] cnv_a,
  input  logic [CW-1:0] cnv_b,
  input  logic [CW-1:0] cnv_tol,
  output logic [1:0]    cnv_mode,
  output logic          busy,
  output logic          block_a,
  output logic          block_b,
  output logic          dual_alarm,
  output logic [2:0]    verdict,
  output logic [W-1:0]  data_out,
  output logic          data_vld
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};
  localparam logic [2:0] S_IDLE = 3'd0, S_BIST = 3'd1, S_TIME = 3'd2, S_CZ = 3'd3, S_CR = 3'd4;

  logic [2:0]    st;
  logic [15:0]   sup_cnt;
  logic [TW-1:0] prev_a, prev_b;
  logic          have_prev, tbad_a, tbad_b;
  logic [3:0]    n_int;

  logic [W-1:0] diff;
  assign diff = (val_a > val_b) ? val_a - val_b : val_b - val_a;
  logic start;
  assign start = (st == S_IDLE) && smp_vld && !block_a && !block_b && (diff > mis_tol);

  logic sup_tick, sup_a, sup_b;
  assign sup_tick = (sup_cnt >= sup_period);
  assign sup_a = sup_tick && !sup_ok_a;
  assign sup_b = sup_tick && !sup_ok_b;

  function automatic logic off_period(input logic [TW-1:0] cur, input logic [TW-1:0] old,
                                      input logic [TW-1:0] per, input logic [TW-1:0] tol);
    logic [TW-1:0] d, e;
    d = cur - old;
    e = (d > per) ? d - per : per - d;
    return e > tol;
  endfunction

  logic int_ev, last_int;
  assign int_ev   = (st == S_TIME) && ts_vld && have_prev;
  assign last_int = int_ev && ({1'b0, n_int} + 5'd1 >= {1'b0, k_int});

  logic       v_fire, v_a, v_b;
  logic [2:0] v_code;
  always_comb begin
    v_fire = 1'b0; v_a = 1'b0; v_b = 1'b0; v_code = 3'd0;
    case (st)
      S_BIST: begin v_fire = 1'b1; v_a = !bist_ok_a; v_b = !bist_ok_b; v_code = 3'd2; end
      S_TIME: begin
        v_fire = last_int;
        v_a = tbad_a || off_period(ts_a, prev_a, ts_period, ts_tol);
        v_b = tbad_b || off_period(ts_b, prev_b, ts_period, ts_tol);
        v_code = 3'd3;
      end
      S_CZ: begin v_fire = cnv_vld; v_a = cnv_a > cnv_tol; v_b = cnv_b > cnv_tol; v_code = 3'd4; end
      S_CR: begin v_fire = cnv_vld; v_a = cnv_a < FULL - cnv_tol; v_b = cnv_b < FULL - cnv_tol; v_code = 3'd5; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; block_a <= 1'b0; block_b <= 1'b0; dual_alarm <= 1'b0; verdict <= 3'd0;
      sup_cnt <= '0;
    end else begin
      sup_cnt <= sup_tick ? '0 : sup_cnt + 16'd1;
      if (clr) begin
        st <= S_IDLE; block_a <= 1'b0; block_b <= 1'b0; dual_alarm <= 1'b0; verdict <= 3'd0;
      end else if (sup_a || sup_b) begin
        st <= S_IDLE;
        block_a <= block_a | sup_a;
        block_b <= block_b | sup_b;
        dual_alarm <= dual_alarm | (sup_a & sup_b);
        verdict <= 3'd1;
      end else if (v_fire) begin
        if (v_a || v_b) begin
          st <= S_IDLE;
          block_a <= block_a | v_a;
          block_b <= block_b | v_b;
          dual_alarm <= dual_alarm | (v_a & v_b);
          verdict <= v_code;
        end else if (st == S_CR) begin
          st <= S_IDLE;
          verdict <= 3'd7;
        end else begin
          st <= st + 3'd1;
        end
      end else if (start) begin
        st <= S_BIST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0; tbad_a <= 1'b0; tbad_b <= 1'b0; n_int <= '0;
      prev_a <= '0; prev_b <= '0;
    end else if (st != S_TIME) begin
      have_prev <= 1'b0; tbad_a <= 1'b0; tbad_b <= 1'b0; n_int <= '0;
    end else if (ts_vld) begin
      prev_a <= ts_a;
      prev_b <= ts_b;
      have_prev <= 1'b1;
      if (have_prev) begin
        n_int  <= n_int + 4'd1;
        tbad_a <= tbad_a | off_period(ts_a, prev_a, ts_period, ts_tol);
        tbad_b <= tbad_b | off_period(ts_b, prev_b, ts_period, ts_tol);
      end
    end
  end

  assign busy     = (st != S_IDLE);
  assign cnv_mode = (st == S_CZ) ? 2'b01 : (st == S_CR) ? 2'b10 : 2'b00;
  assign data_out = (block_a && !block_b) ? val_b : val_a;
  assign data_vld = smp_vld && !(block_a && block_b);
endmodule

// File: rtl/dual_chan_isolator_chk.sv
module dual_chan_isolator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       busy,
  input logic       block_a,
  input logic       block_b,
  input logic       dual_alarm,
  input logic [2:0] verdict,
  input logic [1:0] cnv_mode
);
  a_r8_dual_blocks_both: assert property (@(posedge clk) disable iff (!rst_n)
    dual_alarm |-> (block_a && block_b));
  a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (block_a && !clr) |=> block_a);
  a_r9_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    (block_b && !clr) |=> block_b);
  a_r9_release_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(block_a) || $fell(block_b)) |-> $past(clr));
  a_r9_no_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (block_a || block_b)) |=> !busy);
  a_r7_clean_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == 3'd7) |-> (!block_a && !block_b));
  a_r5_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnv_mode) && (cnv_mode == 2'b00 || busy));
endmodule

bind dual_chan_isolator dual_chan_isolator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .busy(busy), .block_a(block_a), .block_b(block_b),
  .dual_alarm(dual_alarm), .verdict(verdict), .cnv_mode(cnv_mode)
);

// File: tb/dual_chan_isolator_bench.sv
module dual_chan_isolator_bench;
  localparam int CLK_P = 10;
  localparam int W = 16, TW = 32, CW = 12;

  logic clk = 0, rst_n = 0, clr = 0, smp_vld = 0;
  logic [W-1:0] val_a = 0, val_b = 0, mis_tol = 10;
  logic sup_ok_a = 1, sup_ok_b = 1;
  logic [15:0] sup_period = 16'd1000;
  logic bist_ok_a = 1, bist_ok_b = 1, ts_vld = 0, cnv_vld = 0;
  logic [TW-1:0] ts_a = 0, ts_b = 0, ts_period = 100, ts_tol = 3;
  logic [3:0] k_int = 4'd4;
  logic [CW-1:0] cnv_a = 0, cnv_b = 0, cnv_tol = 2;
  logic [1:0] cnv_mode;
  logic busy, block_a, block_b, dual_alarm, data_vld;
  logic [2:0] verdict;
  logic [W-1:0] data_out;

  int n_chk = 0, n_bad = 0;

  dual_chan_isolator #(.W(W), .TW(TW), .CW(CW)) u_dual_chan_isolator (.*);

  always #(CLK_P/2) clk = ~clk;

  // bist_a bist_b per_a per_b zero_a zero_b full_a full_b | blk_a blk_b dual verdict
  localparam int NV = 9;
  localparam logic [71:0] VEC [NV] = '{
    {2'b11, 8'd100, 8'd100, 12'd0, 12'd0, 12'd4095, 12'd4095, 3'b000, 3'd7},
    {2'b01, 8'd100, 8'd100, 12'd0, 12'd0, 12'd4095, 12'd4095, 3'b100, 3'd2},
    {2'b00, 8'd100, 8'd100, 12'd0, 12'd0, 12'd4095, 12'd4095, 3'b111, 3'd2},
    {2'b11, 8'd100, 8'd104, 12'd0, 12'd0, 12'd4095, 12'd4095, 3'b010, 3'd3},
    {2'b11, 8'd103, 8'd97,  12'd0, 12'd0, 12'd4095, 12'd4095, 3'b000, 3'd7},
    {2'b11, 8'd100, 8'd100, 12'd3, 12'd0, 12'd4095, 12'd4095, 3'b100, 3'd4},
    {2'b11, 8'd100, 8'd100, 12'd0, 12'd0, 12'd4095, 12'd4092, 3'b010, 3'd5},
    {2'b11, 8'd100, 8'd100, 12'd3, 12'd5, 12'd4095, 12'd4095, 3'b111, 3'd4},
    {2'b11, 8'd100, 8'd100, 12'd2, 12'd0, 12'd4093, 12'd4093, 3'b000, 3'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1; cyc(1); clr = 0; cyc(1);
  endtask

  task automatic mismatch(input logic [W-1:0] a, input logic [W-1:0] b);
    smp_vld = 1; val_a = a; val_b = b; cyc(1); smp_vld = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(1);
    check("R11 busy", busy, 0);
    check("R11 blocks", {block_a, block_b, dual_alarm}, 0);
    check("R11 verdict", verdict, 0);
    rst_n = 1; cyc(2);

    for (int v = 0; v < NV; v++) begin
      logic [71:0] e;
      e = VEC[v];
      do_clr();
      bist_ok_a = e[71]; bist_ok_b = e[70];
      mismatch(100, 200);
      check("R1 start", busy, 1);
      cyc(2);
      for (int i = 0; i <= 4; i++) begin
        ts_a = 1000 + i * e[69:62]; ts_b = 5000 + i * e[61:54];
        ts_vld = 1; cyc(1); ts_vld = 0; cyc(1);
      end
      // zero step request expected when timing passed: R5
      if (e[5:0] == 6'h07 || e[2:0] >= 3'd4)
        check("R5 zero mode", cnv_mode, 2'b01);
      cnv_a = e[53:42]; cnv_b = e[41:30]; cnv_vld = 1; cyc(1); cnv_vld = 0; cyc(1);
      if (e[2:0] == 3'd7 || e[2:0] == 3'd5)
        check("R6 full mode", cnv_mode, 2'b10);
      cnv_a = e[29:18]; cnv_b = e[17:6]; cnv_vld = 1; cyc(1); cnv_vld = 0; cyc(3);
      check($sformatf("R3/R4/R6/R7 blocks v%0d", v), {block_a, block_b}, e[5:4]);
      check($sformatf("R8 dual v%0d", v), dual_alarm, e[3]);
      check($sformatf("R7 verdict v%0d", v), verdict, e[2:0]);
      check("R1 idle after", busy, 0);
      bist_ok_a = 1; bist_ok_b = 1;
      if (v == 1) begin
        smp_vld = 1; val_a = 5; val_b = 9; #1;
        check("R10 healthy B", data_out, 9);
        check("R10 vld", data_vld, 1);
        cyc(1); smp_vld = 0;
        mismatch(0, 500); cyc(1);
        check("R9 no start while blocked", busy, 0);
        check("R9 still blocked", block_a, 1);
      end
      if (v == 2) begin
        smp_vld = 1; #1;
        check("R10 both blocked invalid", data_vld, 0);
        cyc(1); smp_vld = 0;
      end
    end

    do_clr();
    check("R9 clr verdict", verdict, 0);
    check("R9 clr blocks", {block_a, block_b, dual_alarm}, 0);
    smp_vld = 1; val_a = 7; val_b = 3; #1;
    check("R10 default A", data_out, 7);
    cyc(1); smp_vld = 0;
    mismatch(100, 110); cyc(1);
    check("R1 equal tol no start", busy, 0);
    mismatch(100, 111);
    check("R1 over tol start", busy, 1);
    clr = 1; cyc(1); clr = 0;
    check("R9 clr aborts", busy, 0);

    sup_period = 16'd3; sup_ok_a = 0; cyc(8);
    check("R2 supply block a", {block_a, block_b}, 2'b10);
    check("R2 supply verdict", verdict, 1);
    sup_ok_a = 1; do_clr();
    sup_ok_a = 0; sup_ok_b = 0; cyc(8);
    check("R8 supply dual", {block_a, block_b, dual_alarm}, 3'b111);
    sup_ok_a = 1; sup_ok_b = 1; sup_period = 16'd1000; do_clr();
    check("R9 final clr", {block_a, block_b, dual_alarm, verdict}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule